// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks, so a producer and a consumer can move data at the same time. The storage is a register array inside the block with a depth of two to the power `AW` words. Each pointer crosses to the other clock domain as Gray code through a synchroniser chain. Flags that describe free space are formed on the write clock. Flags that describe available data are formed on the read clock.

There are two read timing modes, and the mode is captured while master reset is held. In standard mode the two main flags mean "array empty" and "array full", and a word reaches the output only after a read request. In fall-through mode the first word is presented on the output without any request. The same two flags then mean "output word ready" and "room to write". A half-full flag and two programmable almost flags complete the status set. The thresholds for the almost flags come in as ports from an offset register outside the block.

Partial reset discards the stored data but keeps the captured mode. Master reset discards everything and captures the mode again. A one-cycle retransmit request moves the read side back to the first word written since the last reset, and that word is available from the very next read edge.

Top module: `dcfifo_flags`

## Requirements
- R1: `fwft_sel` is captured in each clock domain only while master reset is in effect (0 = standard, 1 = fall-through). Changes on `fwft_sel` after master reset is released have no effect until the next master reset.
- R2: In standard mode, `rd_flag` is 1 when the read side sees no stored word, and `wr_flag` is 1 when the write side sees 2**AW stored words. After either reset, `rd_flag`=1 and `wr_flag`=0.
- R3: In standard mode, an rclk edge with `rd_en`=1, `rd_sel`=1 and a non-empty array places the oldest unread word on `dout` at that edge. Words come out in write order.
- R4: With `rd_sel`=0, `rd_en` has no effect. In standard mode the read position and `dout` are unchanged.
- R5: A write while the write side sees the array full is dropped. In standard mode a read while empty leaves `dout` and the read position unchanged.
- R6: In fall-through mode, the oldest word appears on `dout` with `rd_flag`=1 and no read request. A read with `rd_sel`=1 advances to the next word at that edge, or drops `rd_flag` when no word remains. `wr_flag`=1 means there is room to write.
- R7: `half_full` is 1 exactly when the write-side word count is at least 2**(AW-1).
- R8: `almost_empty` is 1 when the read-side held count is at most `ae_off`. The held count is the unread words in the array, plus one in fall-through mode while the output word is ready.
- R9: `almost_full` is 1 when the write-side word count is at least 2**AW − `af_off`.
- R10: Partial reset (`prst_n`=0) empties the FIFO, returns `dout` to 0 and keeps the captured mode.
- R11: Master reset (`mrst_n`=0) empties the FIFO, returns `dout` to 0 and recaptures the mode.
- R12: A one-rclk pulse on `rt_req` moves reading back to the first word written since the last reset. In standard mode the next read returns that word. In fall-through mode that word is on `dout` at the pulse's own edge. This holds when no more than 2**AW words were written since reset and the write side is idle around the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, asynchronous assert |
| fwft_sel | input | 1 | Read timing mode captured during master reset |
| wr_en | input | 1 | Write request |
| din | input | DW | Write data |
| af_off | input | AW | Almost-full offset |
| wr_flag | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | At least half of the depth is occupied |
| almost_full | output | 1 | Almost-full status |
| rd_en | input | 1 | Read request |
| rd_sel | input | 1 | Read select; gates read requests |
| rt_req | input | 1 | Retransmit request |
| ae_off | input | AW | Almost-empty offset |
| dout | output | DW | Read data |
| rd_flag | output | 1 | Empty (standard) or output ready (fall-through) |
| almost_empty | output | 1 | Almost-empty status |

## Verification
A corrupted pointer or a stale synchroniser stage shows first as a wrong word on `dout` at the next read. It also puts the count-derived flags out of step with the number of words the bench has written. Every fill level is checked once the crossing has settled, a few cycles on each clock, so a count that is off by one shows up on `half_full`, `almost_full` or `almost_empty` at a known boundary. A mode register that follows `fwft_sel` after reset shows at once, because `rd_flag` and `wr_flag` take their other meanings. A faulty rewind shows on the first read after the retransmit pulse.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
   typedef enum logic {
      RD_STD  = 1'b0,
      RD_FWFT = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/fifo_rst_sync.sv
module fifo_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);
   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
   end

   assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/fifo_gray_cross.sv
module fifo_gray_cross #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);
   logic [W-1:0] st_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
      end else begin
         st_q[0] <= gray_in;
         for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
      end
   end

   // bit i of the binary value is the XOR of gray bits i and above
   for (genvar i = 0; i < W; i++) begin : g_g2b
      assign bin_out[i] = ^st_q[STAGES-1][W-1:i];
   end
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
   parameter int AW = 4,
   parameter int DW = 16
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
   import dcfifo_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  rd_mode_e      mode,
   input  logic          wr_en,
   input  logic [AW:0]   rbin_s,
   input  logic [AW-1:0] af_off,
   output logic          mem_we,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wptr,
   output logic [AW:0]   wgray,
   output logic [AW:0]   wcnt,
   output logic          wr_flag,
   output logic          half_full,
   output logic          almost_full
);
   localparam int          DEPTH   = 1 << AW;
   localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];
   localparam logic [AW:0] HALF_V  = DEPTH_V >> 1;
   localparam logic [AW:0] ONE_V   = {{AW{1'b0}}, 1'b1};

   logic [AW:0] wptr_q, wgray_q, wptr_nx;
   logic        full;
   logic [AW:0] af_thr;

   assign wcnt    = wptr_q - rbin_s;
   assign full    = (wcnt == DEPTH_V);
   assign mem_we  = wr_en && !full;
   assign wptr_nx = wptr_q + ONE_V;
   assign af_thr  = DEPTH_V - {1'b0, af_off};

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         wgray_q <= '0;
      end else if (mem_we) begin
         wptr_q  <= wptr_nx;
         wgray_q <= wptr_nx ^ (wptr_nx >> 1);
      end
   end

   assign waddr       = wptr_q[AW-1:0];
   assign wptr        = wptr_q;
   assign wgray       = wgray_q;
   assign wr_flag     = (mode == RD_FWFT) ? !full : full;
   assign half_full   = (wcnt >= HALF_V);
   assign almost_full = (wcnt >= af_thr);
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
   import dcfifo_pkg::*;
#(
   parameter int AW = 4,
   parameter int DW = 16
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  rd_mode_e      mode,
   input  logic          rd_en,
   input  logic          rd_sel,
   input  logic          rewind,
   input  logic [AW:0]   wbin_s,
   input  logic [AW-1:0] ae_off,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rptr,
   output logic [AW:0]   rgray,
   output logic [DW-1:0] dout,
   output logic          rd_flag,
   output logic          almost_empty
);
   localparam logic [AW:0] ONE_V = {{AW{1'b0}}, 1'b1};

   logic [AW:0]   rptr_q, rgray_q, rptr_nx, rptr_ld;
   logic [DW-1:0] dout_q;
   logic          valid_q;
   logic [AW:0]   cnt;
   logic          arr_empty, rd_req, take, fwft;
   logic [AW+1:0] held;

   assign fwft      = (mode == RD_FWFT);
   assign cnt       = wbin_s - rptr_q;
   assign arr_empty = (cnt == '0);
   assign rd_req    = rd_en && rd_sel;
   assign raddr     = rewind ? '0 : rptr_q[AW-1:0];

   always_comb begin
      if (rewind)    take = 1'b0;
      else if (fwft) take = !arr_empty && (!valid_q || rd_req);
      else           take = rd_req && !arr_empty;
   end

   assign rptr_nx = rptr_q + ONE_V;
   assign rptr_ld = (fwft && (wbin_s != '0)) ? ONE_V : '0;

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q  <= '0;
         rgray_q <= '0;
         dout_q  <= '0;
         valid_q <= 1'b0;
      end else if (rewind) begin
         rptr_q  <= rptr_ld;
         rgray_q <= rptr_ld ^ (rptr_ld >> 1);
         if (fwft) begin
            valid_q <= (wbin_s != '0);
            if (wbin_s != '0) dout_q <= rdata;
         end
      end else if (take) begin
         rptr_q  <= rptr_nx;
         rgray_q <= rptr_nx ^ (rptr_nx >> 1);
         dout_q  <= rdata;
         valid_q <= fwft;
      end else if (fwft && rd_req && valid_q) begin
         valid_q <= 1'b0;
      end
   end

   assign held         = {1'b0, cnt} + {{(AW+1){1'b0}}, fwft && valid_q};
   assign almost_empty = (held <= {2'b00, ae_off});
   assign rd_flag      = fwft ? valid_q : arr_empty;
   assign rptr         = rptr_q;
   assign rgray        = rgray_q;
   assign dout         = dout_q;
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
   import dcfifo_pkg::*;
#(
   parameter int AW          = 4,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          fwft_sel,
   input  logic          wr_en,
   input  logic [DW-1:0] din,
   input  logic [AW-1:0] af_off,
   output logic          wr_flag,
   output logic          half_full,
   output logic          almost_full,
   input  logic          rd_en,
   input  logic          rd_sel,
   input  logic          rt_req,
   input  logic [AW-1:0] ae_off,
   output logic [DW-1:0] dout,
   output logic          rd_flag,
   output logic          almost_empty
);
   if (AW < 2 || AW > 16) begin : g_bad_aw
      $error("dcfifo_flags: AW must lie in 2..16");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dcfifo_flags: DW must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dcfifo_flags: SYNC_STAGES must be at least 2");
   end

   logic          any_rst_n;
   logic          mrst_w_n, mrst_r_n, wrst_n, rrst_n;
   rd_mode_e      mode_w, mode_r;
   logic          mem_we;
   logic [AW-1:0] waddr, raddr;
   logic [DW-1:0] rdata;
   logic [AW:0]   wr_ptr, wr_gray, wr_cnt, rd_ptr, rd_gray;
   logic [AW:0]   rbin_s, wbin_s;

   assign any_rst_n = mrst_n & prst_n;

   fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_mrs_w (.clk(wclk), .arst_n(mrst_n),    .srst_n(mrst_w_n));
   fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_mrs_r (.clk(rclk), .arst_n(mrst_n),    .srst_n(mrst_r_n));
   fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_w (.clk(wclk), .arst_n(any_rst_n), .srst_n(wrst_n));
   fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_r (.clk(rclk), .arst_n(any_rst_n), .srst_n(rrst_n));

   // mode copies follow the select only while master reset is in effect
   always_ff @(posedge wclk) begin
      if (!mrst_w_n) mode_w <= rd_mode_e'(fwft_sel);
   end
   always_ff @(posedge rclk) begin
      if (!mrst_r_n) mode_r <= rd_mode_e'(fwft_sel);
   end

   fifo_gray_cross #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(wrst_n), .gray_in(rd_gray), .bin_out(rbin_s));
   fifo_gray_cross #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rrst_n), .gray_in(wr_gray), .bin_out(wbin_s));

   fifo_store #(.AW(AW), .DW(DW)) u_store (
      .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(din),
      .raddr(raddr), .rdata(rdata));

   fifo_wr_side #(.AW(AW)) u_wr (
      .wclk(wclk), .rst_n(wrst_n), .mode(mode_w), .wr_en(wr_en),
      .rbin_s(rbin_s), .af_off(af_off), .mem_we(mem_we), .waddr(waddr),
      .wptr(wr_ptr), .wgray(wr_gray), .wcnt(wr_cnt), .wr_flag(wr_flag),
      .half_full(half_full), .almost_full(almost_full));

   fifo_rd_side #(.AW(AW), .DW(DW)) u_rd (
      .rclk(rclk), .rst_n(rrst_n), .mode(mode_r), .rd_en(rd_en),
      .rd_sel(rd_sel), .rewind(rt_req), .wbin_s(wbin_s), .ae_off(ae_off),
      .rdata(rdata), .raddr(raddr), .rptr(rd_ptr), .rgray(rd_gray),
      .dout(dout), .rd_flag(rd_flag), .almost_empty(almost_empty));
endmodule

// File: rtl/fifo_flag_chk.sv
module fifo_flag_chk
   import dcfifo_pkg::*;
#(
   parameter int AW = 4,
   parameter int DW = 16
) (
   input logic          wclk,
   input logic          rclk,
   input logic          wrst_n,
   input logic          rrst_n,
   input logic          mrst_w_n,
   input rd_mode_e      mode_w,
   input rd_mode_e      mode_r,
   input logic          wr_en,
   input logic          rd_en,
   input logic          rd_sel,
   input logic          rt_req,
   input logic          rd_flag,
   input logic          half_full,
   input logic [DW-1:0] dout,
   input logic [AW:0]   wr_ptr,
   input logic [AW:0]   rd_ptr,
   input logic [AW:0]   wr_cnt
);
   localparam int          DEPTH   = 1 << AW;
   localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];
   localparam logic [AW:0] ONE_V   = {{AW{1'b0}}, 1'b1};

   a_r1_mode_hold: assert property (@(posedge wclk) disable iff (!mrst_w_n)
      $stable(mode_w));

   a_r2_count_bound: assert property (@(posedge wclk) disable iff (!wrst_n)
      wr_cnt <= DEPTH_V);

   a_r5_no_overflow: assert property (@(posedge wclk) disable iff (!wrst_n)
      (wr_cnt == DEPTH_V) |=> (wr_ptr == $past(wr_ptr)));

   a_r5_no_underflow: assert property (@(posedge rclk) disable iff (!rrst_n)
      (mode_r == RD_STD && rd_flag && !rt_req) |=> ($stable(rd_ptr) && $stable(dout)));

   a_r4_sel_gates: assert property (@(posedge rclk) disable iff (!rrst_n)
      (mode_r == RD_STD && !rd_sel && !rt_req) |=> $stable(rd_ptr));

   a_r6_ready_drop: assert property (@(posedge rclk) disable iff (!rrst_n)
      (mode_r == RD_FWFT && $fell(rd_flag)) |-> $past(rd_en && rd_sel));

   a_r7_half_rise: assert property (@(posedge wclk) disable iff (!wrst_n)
      $rose(half_full) |-> $past(wr_en));

   a_r12_rewind: assert property (@(posedge rclk) disable iff (!rrst_n)
      rt_req |=> (rd_ptr <= ONE_V));
endmodule

bind dcfifo_flags fifo_flag_chk #(.AW(AW), .DW(DW)) u_chk (
   .wclk(wclk), .rclk(rclk), .wrst_n(wrst_n), .rrst_n(rrst_n),
   .mrst_w_n(mrst_w_n), .mode_w(mode_w), .mode_r(mode_r),
   .wr_en(wr_en), .rd_en(rd_en), .rd_sel(rd_sel), .rt_req(rt_req),
   .rd_flag(rd_flag), .half_full(half_full), .dout(dout),
   .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_cnt(wr_cnt));

// File: tb/tb_dcfifo_flags.sv
module tb_dcfifo_flags;
   localparam int AW    = 4;
   localparam int DW    = 16;
   localparam int DEPTH = 1 << AW;
   localparam int AE    = 2;
   localparam int AF    = 3;

   logic          wclk = 1'b0, rclk = 1'b0;
   logic          mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0, rd_sel = 1'b0, rt_req = 1'b0;
   logic [DW-1:0] din = '0;
   logic [AW-1:0] af_off = AW'(AF), ae_off = AW'(AE);
   logic          wr_flag, half_full, almost_full, rd_flag, almost_empty;
   logic [DW-1:0] dout;

   int            n_chk = 0, n_bad = 0;
   bit            done  = 1'b0;
   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] hist[$];
   logic [DW-1:0] last;

   always #2.5 wclk = ~wclk;
   always #3.5 rclk = ~rclk;

   dcfifo_flags #(.AW(AW), .DW(DW), .SYNC_STAGES(2)) dut (
      .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
      .fwft_sel(fwft_sel), .wr_en(wr_en), .din(din), .af_off(af_off),
      .wr_flag(wr_flag), .half_full(half_full), .almost_full(almost_full),
      .rd_en(rd_en), .rd_sel(rd_sel), .rt_req(rt_req), .ae_off(ae_off),
      .dout(dout), .rd_flag(rd_flag), .almost_empty(almost_empty));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (8) @(negedge rclk);
      repeat (8) @(negedge wclk);
   endtask

   task automatic both_wait(int n);
      repeat (n) @(negedge wclk);
      repeat (n) @(negedge rclk);
   endtask

   task automatic master_reset(logic mode);
      mrst_n = 1'b0; fwft_sel = mode;
      both_wait(6);
      mrst_n = 1'b1;
      both_wait(6);
      fwft_sel = ~mode;               // must be ignored from here on
      exp_q.delete(); hist.delete();
   endtask

   task automatic partial_reset();
      prst_n = 1'b0;
      both_wait(4);
      prst_n = 1'b1;
      both_wait(6);
      exp_q.delete(); hist.delete();
   endtask

   // driver: writes one word and records it when the model has room
   task automatic push(logic [DW-1:0] d);
      @(negedge wclk); wr_en = 1'b1; din = d;
      @(negedge wclk); wr_en = 1'b0;
      if (exp_q.size() < DEPTH) begin
         exp_q.push_back(d);
         hist.push_back(d);
      end
   endtask

   // monitor for standard mode: request, then compare the word shown
   task automatic pop_std(string tag);
      logic [DW-1:0] e;
      @(negedge rclk); rd_en = 1'b1; rd_sel = 1'b1;
      @(negedge rclk); rd_en = 1'b0;
      e = exp_q.pop_front();
      chk(tag, 32'(dout), 32'(e));
      last = dout;
   endtask

   // monitor for fall-through mode: compare the word shown, then consume
   task automatic pop_fwft(string tag);
      logic [DW-1:0] e;
      e = exp_q.pop_front();
      chk(tag, 32'(dout), 32'(e));
      @(negedge rclk); rd_en = 1'b1; rd_sel = 1'b1;
      @(negedge rclk); rd_en = 1'b0;
   endtask

   task automatic retransmit();
      @(negedge rclk); rt_req = 1'b1;
      @(negedge rclk); rt_req = 1'b0;
      exp_q = hist;
   endtask

   initial begin
      // ---- standard mode, reset state
      master_reset(1'b0);
      chk("R2 empty after reset", 32'(rd_flag), 1);
      chk("R2 not full after reset", 32'(wr_flag), 0);
      chk("R11 dout zero after reset", 32'(dout), 0);
      chk("R8 almost_empty at zero", 32'(almost_empty), 1);
      chk("R7 half_full at zero", 32'(half_full), 0);

      // ---- ordered reads
      for (int i = 0; i < 5; i++) push(16'h1100 + 16'(i));
      settle();
      chk("R2 not empty", 32'(rd_flag), 0);
      for (int i = 0; i < 5; i++) pop_std("R3 read order");
      settle();
      chk("R2 empty after drain", 32'(rd_flag), 1);

      // ---- read select gating
      push(16'h2200); push(16'h2201);
      settle();
      @(negedge rclk); rd_en = 1'b1; rd_sel = 1'b0;
      repeat (3) @(negedge rclk);
      rd_en = 1'b0;
      chk("R4 dout held without select", 32'(dout), 32'(last));
      chk("R4 still not empty", 32'(rd_flag), 0);
      pop_std("R4 first word after gated reads");
      pop_std("R4 second word");

      // ---- incremental fill, flag thresholds
      partial_reset();
      chk("R10 empty after partial reset", 32'(rd_flag), 1);
      chk("R10 dout zero after partial reset", 32'(dout), 0);
      for (int k = 1; k <= DEPTH; k++) begin
         push(16'h3300 + 16'(k));
         settle();
         chk("R2 full flag", 32'(wr_flag), 32'(k == DEPTH));
         chk("R7 half_full", 32'(half_full), 32'(k >= DEPTH/2));
         chk("R9 almost_full", 32'(almost_full), 32'(k >= DEPTH - AF));
         chk("R8 almost_empty", 32'(almost_empty), 32'(k <= AE));
      end
      push(16'hDEAD);                 // dropped, model is at capacity
      settle();
      chk("R5 still full", 32'(wr_flag), 1);
      for (int k = 0; k < DEPTH; k++) pop_std("R5 drain after overflow");
      settle();
      chk("R5 empty, extra word absent", 32'(rd_flag), 1);
      @(negedge rclk); rd_en = 1'b1; rd_sel = 1'b1;
      @(negedge rclk); rd_en = 1'b0;
      chk("R5 dout held on empty read", 32'(dout), 32'(last));

      // ---- retransmit, standard mode
      partial_reset();
      for (int i = 0; i < 4; i++) push(16'h4400 + 16'(i));
      settle();
      pop_std("R3 before rewind");
      pop_std("R3 before rewind");
      retransmit();
      for (int i = 0; i < 4; i++) pop_std("R12 replay in standard mode");
      settle();
      chk("R12 empty after replay", 32'(rd_flag), 1);

      // ---- fall-through mode
      master_reset(1'b1);
      chk("R6 not ready after reset", 32'(rd_flag), 0);
      chk("R6 input ready after reset", 32'(wr_flag), 1);
      for (int i = 0; i < 3; i++) push(16'h5500 + 16'(i));
      settle();
      chk("R6 ready without read", 32'(rd_flag), 1);
      chk("R1 mode kept despite select change", 32'(rd_flag), 1);
      chk("R6 first word presented", 32'(dout), 32'h5500);
      chk("R8 held count three", 32'(almost_empty), 0);
      pop_fwft("R6 word 0");
      @(negedge rclk);
      chk("R8 held count two", 32'(almost_empty), 1);
      pop_fwft("R6 word 1");
      for (int i = 3; i < 6; i++) push(16'h5500 + 16'(i));
      settle();
      retransmit();
      chk("R12 first word on rewind edge", 32'(dout), 32'h5500);
      chk("R12 ready after rewind", 32'(rd_flag), 1);
      for (int i = 0; i < 6; i++) pop_fwft("R12 replay in fall-through mode");
      settle();
      chk("R6 not ready when drained", 32'(rd_flag), 0);

      // ---- partial reset keeps fall-through mode
      partial_reset();
      chk("R10 not ready after partial reset", 32'(rd_flag), 0);
      chk("R10 input ready kept", 32'(wr_flag), 1);
      push(16'h6600);
      settle();
      chk("R10 mode kept, word falls through", 32'(dout), 32'h6600);

      // ---- master reset recaptures standard mode
      master_reset(1'b0);
      chk("R11 empty flag meaning restored", 32'(rd_flag), 1);
      chk("R11 full flag meaning restored", 32'(wr_flag), 0);
      push(16'h7700);
      settle();
      chk("R11 no fall-through in standard mode", 32'(dout), 0);
      pop_std("R11 standard read");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge wclk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule